// File: doc/BRIEF.md
# Dual-Role Synchronous Serial Port

A byte-wide full-duplex serial port for SPI links. It can act as the bus master, which generates the serial clock, or as a slave, which follows an external clock. One shift register sends a byte out on the data output while it takes a byte in from the data input. A separate receive buffer captures the incoming byte when the transfer completes. The host starts a transfer by writing a byte. It collects the received byte by reading the buffer and pulsing a read strobe. Status flags report a waiting byte, a write made during a transfer, and a byte lost because the buffer was still occupied.

A 4-bit mode input selects the role. In the master role it also selects the clock source: the system clock divided by a fixed ratio, or an external tick divided by two. In the slave role it selects whether a low-active select input gates the port. Three more inputs choose the SPI timing. The first sets the idle clock level. The second sets which clock edge moves the data. The third, in the master role, delays input sampling by half a bit.

Top module: `spi_port`

## Requirements
- R1: Each transfer moves exactly 8 bits, MSB first, in both directions at once. The byte written by the host appears on `sdo`, and the byte on `sdi` ends up in the receive buffer.
- R2: The mode input uses these codes: 0 = master, clock divided by DIV_A; 1 = master, divided by DIV_B; 2 = master, divided by DIV_C; 3 = master, one half clock period per `tmr_tick` pulse; 4 = slave with `ss_n` enabled; 5 = slave with `ss_n` ignored. Codes 6 to 15 switch the port off: `sck_oe` and `sdo_oe` are low and a host write starts nothing.
- R3: In master modes 0 to 2, `sck_oe` is high and the serial clock toggles every DIV/2 system clocks (2, 8 or 32 with the defaults).
- R4: In master mode 3, the serial clock toggles once per `tmr_tick` pulse, so one clock period spans two ticks.
- R5: The serial clock idles at `cpol`. With `cpha`=0, a bit is on `sdo` before the first edge and is sampled on the leading edges (edges 1, 3, ..). With `cpha`=1, `sdo` changes on the leading edges and is sampled on the trailing edges.
- R6: In the master role, `smp`=1 samples `sdi` half a clock period later than `smp`=0, at the end of the bit time instead of its middle.
- R7: `buf_full` is low after reset. It rises when a received byte is loaded into the buffer and falls after a `rd_en` pulse.
- R8: In mode 4, while `ss_n` is high, `sdo_oe` is low, clock edges are ignored and a partly received byte is discarded.
- R9: In mode 5, `ss_n` has no effect: `sdo_oe` stays high and transfers complete normally.
- R10: A host write made while a transfer is running sets `wcol` and is ignored: the running transfer still sends its original byte.
- R11: A byte that completes while `buf_full` is high sets `ovfl`, and the buffer keeps the earlier byte.
- R12: A `clr_flags` pulse clears `wcol` and `ovfl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Low-active reset |
| mode | input | 4 | Role and clock source code |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0: data ready before the first edge; 1: data moves on leading edges |
| smp | input | 1 | Master late-sample select |
| wr_en | input | 1 | Host write strobe; starts a transfer |
| wr_data | input | W | Byte to send |
| rd_en | input | 1 | Host read strobe; clears `buf_full` |
| rd_data | output | W | Receive buffer |
| clr_flags | input | 1 | Clears `wcol` and `ovfl` |
| busy | output | 1 | Transfer in progress |
| buf_full | output | 1 | Unread byte in the buffer |
| wcol | output | 1 | Write-collision flag |
| ovfl | output | 1 | Receive-overflow flag |
| tmr_tick | input | 1 | External timer pulse for mode 3 |
| sck_out | output | 1 | Serial clock driven in the master role |
| sck_oe | output | 1 | Serial clock output enable |
| sck_in | input | 1 | Serial clock input in the slave role |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data out enable |
| sdi | input | 1 | Serial data in |
| ss_n | input | 1 | Slave select, low active |

## Verification
The bench uses the default parameters: W = 8 and dividers of 4, 16 and 64. With these values all three prescaled half periods (2, 8 and 32 clocks) can be measured within the cycle budget, and a 64-divided transfer takes only about 550 clocks. The timer tick is generated every third clock, which gives a 3-clock half period that matches none of the fixed dividers. In each master transfer the bench peer moves its data either on leading or on trailing edges. Under `smp`=1 the bench can therefore detect a half-period shift of the sample point as a changed received byte.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int W     = 8,
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int DIV_C = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   mode,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         smp,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  input  logic         clr_flags,
  output logic         busy,
  output logic         buf_full,
  output logic         wcol,
  output logic         ovfl,
  input  logic         tmr_tick,
  output logic         sck_out,
  output logic         sck_oe,
  input  logic         sck_in,
  output logic         sdo,
  output logic         sdo_oe,
  input  logic         sdi,
  input  logic         ss_n
);
  localparam int HW = $clog2(2*W+2);
  localparam int CW = $clog2(DIV_C/2);
  localparam int BW = $clog2(W+1);
  localparam logic [HW-1:0] H_END  = HW'(2*W);
  localparam logic [HW-1:0] H_LAST = HW'(2*W+1);
  localparam logic [HW-1:0] H_3    = HW'(3);
  localparam logic [BW-1:0] B_LAST = BW'(W-1);

  logic          mbusy, ph, dout, sck_d;
  logic [HW-1:0] hcnt, hn;
  logic [CW-1:0] pcnt, plim;
  logic [BW-1:0] bitcnt;
  logic [W-1:0]  shreg, rbuf, shnext;

  wire is_mst   = (mode[3:2] == 2'b00);
  wire is_slv   = (mode == 4'd4) || (mode == 4'd5);
  wire is_slvss = (mode == 4'd4);
  wire on       = is_mst || is_slv;
  wire ss_block = is_slvss && ss_n;

  always_comb begin
    case (mode[1:0])
      2'd0:    plim = CW'(DIV_A/2 - 1);
      2'd1:    plim = CW'(DIV_B/2 - 1);
      default: plim = CW'(DIV_C/2 - 1);
    endcase
  end

  wire htick  = mbusy && ((mode[1:0] == 2'd3) ? tmr_tick : (pcnt == plim));
  assign hn   = hcnt + 1'b1;
  wire m_edge = (hn <= H_END);
  wire m_samp = htick && ((smp && cpha) ? (hn[0] && hn >= H_3) : (smp ^ cpha ^ hn[0]));
  wire m_out  = htick && m_edge && (cpha ? hn[0] : (!hn[0] && hn < H_END));
  wire m_done = htick && (hn == ((smp && cpha) ? H_LAST : H_END));

  wire s_edge  = is_slv && !ss_block && (sck_in != sck_d);
  wire s_lead  = s_edge && (sck_d == cpol);
  wire s_trail = s_edge && (sck_d != cpol);
  wire s_samp  = cpha ? s_trail : s_lead;
  wire s_out   = cpha ? s_lead : s_trail;

  wire samp  = is_mst ? m_samp : s_samp;
  wire outev = is_mst ? m_out : s_out;
  wire last  = samp && (bitcnt == B_LAST);
  wire done  = is_mst ? m_done : last;
  assign shnext = samp ? {shreg[W-2:0], sdi} : shreg;

  assign busy  = is_mst ? mbusy : (bitcnt != '0);
  wire   start = wr_en && on && !busy;
  wire   coll  = wr_en && on && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mbusy <= 1'b0; ph <= 1'b0; dout <= 1'b0; sck_d <= 1'b0;
      hcnt <= '0; pcnt <= '0; bitcnt <= '0; shreg <= '0;
    end else begin
      sck_d <= sck_in;
      if (!on) begin
        mbusy <= 1'b0; ph <= 1'b0; hcnt <= '0; bitcnt <= '0;
      end else if (start) begin
        shreg <= wr_data; dout <= wr_data[W-1];
        bitcnt <= '0; hcnt <= '0; pcnt <= '0; ph <= 1'b0;
        mbusy <= is_mst;
      end else begin
        if (htick) pcnt <= '0;
        else if (mbusy) pcnt <= pcnt + 1'b1;
        if (htick) begin
          hcnt <= hn;
          if (m_edge) ph <= ~ph;
        end
        if (samp) begin
          shreg  <= shnext;
          bitcnt <= last ? '0 : bitcnt + 1'b1;
        end
        if (outev) dout <= samp ? shreg[W-2] : shreg[W-1];
        if (m_done) mbusy <= 1'b0;
        if (ss_block) bitcnt <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbuf <= '0; buf_full <= 1'b0; wcol <= 1'b0; ovfl <= 1'b0;
    end else begin
      if (rd_en) buf_full <= 1'b0;
      if (clr_flags) begin
        wcol <= 1'b0; ovfl <= 1'b0;
      end
      if (coll) wcol <= 1'b1;
      if (done) begin
        if (buf_full && !rd_en) ovfl <= 1'b1;
        else begin
          rbuf <= shnext; buf_full <= 1'b1;
        end
      end
    end
  end

  assign rd_data = rbuf;
  assign sck_out = mbusy ? (cpol ^ ph) : cpol;
  assign sck_oe  = is_mst;
  assign sdo     = dout;
  assign sdo_oe  = is_mst || (mode == 4'd5) || (is_slvss && !ss_n);

  assert_bitcount_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt < BW'(W)) else $error("bit counter past byte length");
  assert_clock_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mbusy) |-> !ph) else $error("serial clock not back at idle");
  assert_buffer_loaded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> buf_full) else $error("completed byte not flagged");
  assert_select_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_slvss && ss_n) |=> (bitcnt == '0)) else $error("partial byte kept");
  assert_collision_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && on && busy && !clr_flags) |=> wcol) else $error("collision missed");
  assert_no_overwrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovfl) |-> $stable(rbuf)) else $error("buffer overwritten on overflow");
endmodule

// File: tb/spi_port_bench.sv
module spi_port_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] mode = 4'd7;
  logic cpol = 0, cpha = 0, smp = 0, wr_en = 0, rd_en = 0, clr_flags = 0;
  logic tmr_tick = 0, sck_in = 0, sdi = 0, ss_n = 1;
  logic [7:0] wr_data = 0, rd_data;
  logic busy, buf_full, wcol, ovfl, sck_out, sck_oe, sdo, sdo_oe;
  int checks = 0, bad = 0, tdiv = 0;

  spi_port u_spi_port (.clk, .rst_n, .mode, .cpol, .cpha, .smp, .wr_en, .wr_data,
    .rd_en, .rd_data, .clr_flags, .busy, .buf_full, .wcol, .ovfl, .tmr_tick,
    .sck_out, .sck_oe, .sck_in, .sdo, .sdo_oe, .sdi, .ss_n);

  always #2 clk = ~clk;

  initial forever begin
    @(negedge clk);
    tdiv = (tdiv == 2) ? 0 : tdiv + 1;
    tmr_tick = (tdiv == 0);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); v = rd_data; rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  function automatic logic [7:0] exp_rx(logic [7:0] pb, logic ph_, logic sp, logic plead);
    int k = 0, n = 0;
    logic [7:0] r = 0;
    logic s;
    for (int h = 1; h <= 17; h++) begin
      if (sp && ph_) s = (h % 2 == 1) && (h >= 3);
      else s = (sp ^ ph_ ^ (h % 2 == 1)) && (h <= 16);
      if (s && n < 8) begin
        r = {r[6:0], (k <= 7) ? pb[7-k] : 1'b0};
        n++;
      end
      if (h <= 16 && ((h % 2 == 1) == plead)) k++;
    end
    return r;
  endfunction

  task automatic mxfer(input logic [3:0] md, input logic pl, input logic ph_, input logic sp,
                       input logic [7:0] tx, input logic [7:0] pb, input logic plead,
                       input logic cw, output logic [7:0] lst, output int gap);
    int h, k, cyc, t1, t2;
    logic prev;
    @(negedge clk); mode = md; cpol = pl; cpha = ph_; smp = sp; sdi = pb[7]; sck_in = pl;
    @(negedge clk); wr_en = 1; wr_data = tx;
    @(negedge clk); wr_en = 0;
    h = 0; k = 0; cyc = 0; t1 = 0; t2 = 0; lst = 0; prev = pl;
    while (1) begin
      if (sck_out !== prev) begin
        h++;
        if (h == 1) t1 = cyc;
        if (h == 2) t2 = cyc;
        if ((h % 2 == 1) == !ph_) lst = {lst[6:0], sdo};
        if ((h % 2 == 1) == plead) begin
          k++;
          sdi = (k <= 7) ? pb[7-k] : 1'b0;
        end
        prev = sck_out;
      end
      if (!busy || cyc > 4000) break;
      @(negedge clk); cyc++;
      wr_en = cw && (cyc == 5);
      wr_data = ~tx;
    end
    wr_en = 0;
    gap = t2 - t1;
  endtask

  task automatic sset(input logic [3:0] md, input logic pl, input logic ph_);
    @(negedge clk); mode = 4'd7; cpol = pl; cpha = ph_; sck_in = pl;
    wt(2); mode = md; wt(2);
  endtask

  task automatic sxfer(input logic pl, input logic ph_, input logic [7:0] tx, input int nb,
                       output logic [7:0] got);
    got = 0;
    for (int i = 7; i > 7 - nb; i--) begin
      if (!ph_) begin
        sdi = tx[i]; wt(4); sck_in = ~pl; wt(4);
        got = {got[6:0], sdo}; sck_in = pl; wt(4);
      end else begin
        sck_in = ~pl; wt(4); sdi = tx[i]; wt(4);
        sck_in = pl; wt(4); got = {got[6:0], sdo};
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [7:0] lst, v, tx, pb, a;
    int gap;
    int halfexp[4] = '{2, 8, 32, 3};
    void'($urandom(32'd2718));
    wt(5); rst_n = 1; wt(2);
    chk("R7 reset buf_full", buf_full, 0);
    chk("R10 reset wcol", wcol, 0);
    chk("R11 reset ovfl", ovfl, 0);
    chk("R2 off sck_oe", sck_oe, 0);
    chk("R2 off sdo_oe", sdo_oe, 0);
    chk("R1 reset busy", busy, 0);

    mode = 4'hA; wr(8'h5A); wt(40);
    chk("R2 off write ignored busy", busy, 0);
    chk("R2 off sck_oe", sck_oe, 0);
    mode = 4'd0; wt(40);
    chk("R2 no pending start", busy, 0);
    chk("R2 clock idle", sck_out, 0);

    for (int md = 0; md < 4; md++) begin
      tx = 8'hA5 ^ 8'(md * 17); pb = 8'h3C + 8'(md);
      mxfer(4'(md), 0, 0, 0, tx, pb, 1, 0, lst, gap);
      chk("R1 master sent byte", lst, tx);
      chk(md == 3 ? "R4 tick half period" : "R3 divided half period", gap, halfexp[md]);
      chk("R3 sck_oe master", sck_oe, 1);
      rd(v);
      chk("R1 master received byte", v, exp_rx(pb, 0, 0, 1));
    end

    for (int c = 0; c < 8; c++) begin
      logic pl, ph_, sp, plead;
      pl = c[2]; ph_ = c[1]; sp = c[0]; plead = c[0] ^ c[2];
      tx = 8'($urandom); pb = 8'($urandom);
      mxfer(4'd0, pl, ph_, sp, tx, pb, plead, 0, lst, gap);
      chk("R5 phase sent byte", lst, tx);
      chk("R5 idle level after", sck_out, pl);
      rd(v);
      chk("R6 sample point", v, exp_rx(pb, ph_, sp, plead));
    end

    for (int it = 0; it < 30; it++) begin
      logic [3:0] md;
      logic pl, ph_, sp, plead;
      md = 4'($urandom % 4);
      if (md == 4'd2 && ($urandom % 3) != 0) md = 4'd1;
      pl = 1'($urandom); ph_ = 1'($urandom); sp = 1'($urandom); plead = 1'($urandom);
      tx = 8'($urandom); pb = 8'($urandom);
      mxfer(md, pl, ph_, sp, tx, pb, plead, 0, lst, gap);
      chk("R1 random sent", lst, tx);
      chk(md == 3 ? "R4 random gap" : "R3 random gap", gap, halfexp[md]);
      rd(v);
      chk("R6 random received", v, exp_rx(pb, ph_, sp, plead));
    end

    mxfer(4'd0, 0, 1, 0, 8'h11, 8'hC3, 0, 0, lst, gap);
    wt(1);
    chk("R7 full after transfer", buf_full, 1);
    rd(v); wt(1);
    chk("R7 cleared by read", buf_full, 0);

    mxfer(4'd0, 1, 0, 0, 8'h22, 8'h96, 1, 0, lst, gap);
    a = exp_rx(8'h96, 0, 0, 1);
    mxfer(4'd0, 1, 0, 0, 8'h33, 8'h0F, 1, 0, lst, gap);
    wt(1);
    chk("R11 overflow flag", ovfl, 1);
    chk("R11 buffer keeps first", rd_data, a);
    @(negedge clk); clr_flags = 1; @(negedge clk); clr_flags = 0;
    chk("R12 overflow cleared", ovfl, 0);
    rd(v);

    mxfer(4'd1, 0, 0, 0, 8'hE7, 8'h18, 1, 1, lst, gap);
    chk("R10 original byte sent", lst, 8'hE7);
    chk("R10 collision flag", wcol, 1);
    rd(v);
    chk("R10 received unaffected", v, exp_rx(8'h18, 0, 0, 1));
    @(negedge clk); clr_flags = 1; @(negedge clk); clr_flags = 0;
    chk("R12 collision cleared", wcol, 0);

    for (int c = 0; c < 4; c++) begin
      logic [7:0] sv, mv, got;
      sv = 8'($urandom); mv = 8'($urandom);
      sset(4'd5, c[1], c[0]); ss_n = 1;
      wr(sv); wt(2);
      chk("R9 sdo driven without select", sdo_oe, 1);
      sxfer(c[1], c[0], mv, 8, got);
      chk("R9 slave sent byte", got, sv);
      rd(v);
      chk("R9 slave received byte", v, mv);
    end

    begin
      logic [7:0] got;
      sset(4'd4, 0, 0); ss_n = 1;
      wr(8'h6D); wt(2);
      chk("R8 sdo off while deselected", sdo_oe, 0);
      sxfer(0, 0, 8'hFF, 3, got);
      chk("R8 edges ignored deselected", busy, 0);
      ss_n = 0; wt(2);
      chk("R8 sdo on when selected", sdo_oe, 1);
      sxfer(0, 0, 8'hFF, 3, got);
      chk("R8 partial byte in progress", busy, 1);
      ss_n = 1; wt(2);
      chk("R8 partial discarded", busy, 0);
      chk("R8 no byte loaded", buf_full, 0);
      ss_n = 0; wt(2);
      sxfer(0, 0, 8'h4B, 8, got);
      rd(v);
      chk("R8 full byte after reselect", v, 8'h4B);
    end

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule